// File: doc/BRIEF.md
# Modem Status Change Detector

This block holds the modem control register and the modem status register of a single serial channel. It takes the four active-low modem inputs (clear to send, data set ready, ring indicator, carrier detect) and passes each one through a synchronizer. It then shows the current levels with asserted meaning 1. Change flags stay set until the host reads the status register. The ring flag is set only when a ring burst ends.

The control register drives four active-low outputs: terminal ready, request to send, and two general-purpose outputs. The same register holds a loopback bit. In loopback the four outputs are held inactive, and the control bits take the place of the modem inputs, so software can exercise the status logic without any cable. When the enable input is high and any change flag is set, the block requests a modem-status interrupt.

Top module: `mdm_ctrl_stat`

## Requirements
- R1: Status bits 7..4 report the current levels of carrier detect, ring, data set ready and clear to send, in that order from bit 7 down. An input pin at 0 reads as 1.
- R2: Status bits 3, 1 and 0 set on any change of carrier detect, data set ready and clear to send respectively. Each stays set until a status read.
- R3: Status bit 2 sets only when the ring level goes from asserted to deasserted. The start of a ring does not set it.
- R4: A status read (`stat_rd` high for one cycle) clears the change flags. A change detected in the same cycle as the read is kept and stays visible after the read.
- R5: A control write stores bits 4..0. The control readback returns those bits with bits 7..5 reading 0.
- R6: With loopback off, `dtr_n`, `rts_n`, `out1_n` and `out2_n` are the inverses of control bits 0, 1, 2 and 3.
- R7: With control bit 4 set, all four outputs stay at 1. The status levels then follow control bits: bit 0 as data set ready, bit 1 as clear to send, bit 2 as ring and bit 3 as carrier detect. The external input pins have no effect.
- R8: `irq` is 1 exactly when `msi_en` is 1 and at least one change flag is set. It is 0 whenever `msi_en` is 0.
- R9: After reset the control register is 0, every flag and level reads 0, all four outputs are 1 and `irq` is 0.
- R10: A pin change driven before clock edge k is not visible after edge k+1. It is visible in both level and flag after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | One-cycle write strobe for the control register |
| wr_data | input | 8 | Write data |
| stat_rd | input | 1 | One-cycle status read strobe; clears change flags |
| msi_en | input | 1 | Modem-status interrupt enable |
| ctrl_q | output | 8 | Control register readback |
| stat_q | output | 8 | Status register: levels 7..4, change flags 3..0 |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that `stat_rd` and `ctrl_wr` are single-cycle strobes. They also assume that each modem pin, once changed, holds long enough to cross the two synchronizer stages. Otherwise a pulse shorter than a clock could be missed, and no property covers that. The stimulus holds every pin, control and enable change for at least four cycles before the next operation. The only exception is one directed case, where a read is placed on purpose in the cycle in which a change reaches the flags.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  // Asserted-high modem line set; packed order matches status bits 7..4 / 3..0
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;

  localparam int LINE_N   = 4;
  localparam int BIT_DTR  = 0;
  localparam int BIT_RTS  = 1;
  localparam int BIT_OUT1 = 2;
  localparam int BIT_OUT2 = 3;
  localparam int BIT_LOOP = 4;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= RST_VAL;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_BITS-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              loop_en,
  output mdm_lines_t        loop_lvl,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n
);
  logic [CTRL_BITS-1:0] ctrl_r, ctrl_nxt;
  logic [LINE_N-1:0]    pins_n;

  always_comb begin
    ctrl_nxt = wr ? wdata : ctrl_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_r <= '0;
      pins_n <= '1;
    end else begin
      ctrl_r <= ctrl_nxt;
      // outputs registered from the next value so they track ctrl_r exactly
      pins_n <= ctrl_nxt[BIT_LOOP] ? '1 : ~ctrl_nxt[LINE_N-1:0];
    end
  end

  assign ctrl_q  = DATA_W'(ctrl_r);
  assign loop_en = ctrl_r[BIT_LOOP];
  always_comb begin
    loop_lvl.dsr = ctrl_r[BIT_DTR];
    loop_lvl.cts = ctrl_r[BIT_RTS];
    loop_lvl.ri  = ctrl_r[BIT_OUT1];
    loop_lvl.dcd = ctrl_r[BIT_OUT2];
  end

  assign dtr_n  = pins_n[BIT_DTR];
  assign rts_n  = pins_n[BIT_RTS];
  assign out1_n = pins_n[BIT_OUT1];
  assign out2_n = pins_n[BIT_OUT2];

  AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    loop_en |-> (dtr_n && rts_n && out1_n && out2_n)); // R7
endmodule

// File: rtl/mdm_stat.sv
module mdm_stat
  import mdm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_N-1:0] pin_sync_n,
  input  logic              loop_en,
  input  mdm_lines_t        loop_lvl,
  input  logic              rd,
  input  logic              int_en,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq
);
  mdm_lines_t lvl_q, lvl_nxt, chg, flag_q, flag_nxt;

  always_comb begin
    lvl_nxt = loop_en ? loop_lvl : mdm_lines_t'(~pin_sync_n);
    chg.cts = lvl_nxt.cts ^ lvl_q.cts;
    chg.dsr = lvl_nxt.dsr ^ lvl_q.dsr;
    chg.dcd = lvl_nxt.dcd ^ lvl_q.dcd;
    chg.ri  = lvl_q.ri & ~lvl_nxt.ri;          // trailing edge only
    flag_nxt = (rd ? mdm_lines_t'('0) : flag_q) | chg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= '0;
      flag_q <= '0;
      irq    <= 1'b0;
    end else begin
      lvl_q  <= lvl_nxt;
      flag_q <= flag_nxt;
      irq    <= int_en & (|flag_nxt);
    end
  end

  assign stat_q = DATA_W'({lvl_q, flag_q});

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q.cts && !rd) |=> flag_q.cts); // R2
  AST_RI_TRAIL: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q.ri) |-> ($past(lvl_q.ri) && !lvl_q.ri)); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd && (lvl_nxt == lvl_q)) |=> (flag_q == '0)); // R4
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    !int_en |=> !irq); // R8
endmodule

// File: rtl/mdm_ctrl_stat.sv
module mdm_ctrl_stat
  import mdm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_BITS = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  input  logic              msi_en,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] stat_q,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n,
  output logic              irq
);
  logic [LINE_N-1:0] pin_raw_n, pin_sync_n;
  logic              loop_en;
  mdm_lines_t        loop_lvl;
  logic              unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CTRL_BITS];
  assign pin_raw_n = {dcd_n, ri_n, dsr_n, cts_n};

  mdm_sync #(.W(LINE_N), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d(pin_raw_n), .q(pin_sync_n)
  );

  mdm_ctrl_reg #(.DATA_W(DATA_W), .CTRL_BITS(CTRL_BITS)) u_ctrl (
    .clk(clk), .rst(rst), .wr(ctrl_wr), .wdata(wr_data[CTRL_BITS-1:0]),
    .ctrl_q(ctrl_q), .loop_en(loop_en), .loop_lvl(loop_lvl),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n)
  );

  mdm_stat #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .pin_sync_n(pin_sync_n), .loop_en(loop_en),
    .loop_lvl(loop_lvl), .rd(stat_rd), .int_en(msi_en),
    .stat_q(stat_q), .irq(irq)
  );
endmodule

// File: tb/tb_mdm_ctrl_stat.sv
module tb_mdm_ctrl_stat;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic ctrl_wr = 1'b0, stat_rd = 1'b0, msi_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_q, stat_q;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic dtr_n, rts_n, out1_n, out2_n, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model state
  logic [3:0] m_pins_n = 4'hF;   // {dcd,ri,dsr,cts} active low
  logic [4:0] m_ctrl = '0;
  logic [3:0] m_lvl = '0, m_flags = '0;
  logic       m_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdm_ctrl_stat dut (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wr_data(wr_data),
    .stat_rd(stat_rd), .msi_en(msi_en), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n), .irq(irq)
  );

  function automatic logic [3:0] lvl_of(logic [3:0] p_n, logic [4:0] c);
    if (c[4]) return {c[3], c[2], c[0], c[1]};   // R7 mapping
    return ~p_n;                                  // R1 inversion
  endfunction

  function automatic logic [3:0] chg_of(logic [3:0] o, logic [3:0] n);
    return {o[3] ^ n[3], o[2] & ~n[2], o[1] ^ n[1], o[0] ^ n[0]};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update();
    logic [3:0] nl;
    nl = lvl_of(m_pins_n, m_ctrl);
    m_flags = m_flags | chg_of(m_lvl, nl);
    m_lvl = nl;
  endtask

  task automatic check_all();
    chk("R1/R7 levels", {4'h0, stat_q[7:4]}, {4'h0, m_lvl});
    chk("R2/R3/R4 flags", {4'h0, stat_q[3:0]}, {4'h0, m_flags});
    chk("R5 ctrl readback", ctrl_q, {3'b000, m_ctrl});
    chk("R6/R7 outputs", {4'h0, out2_n, out1_n, rts_n, dtr_n},
        {4'h0, (m_ctrl[4] ? 4'hF : ~m_ctrl[3:0])});
    chk("R8 irq", {7'h0, irq}, {7'h0, m_en & (|m_flags)});
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pins(logic [3:0] p);
    @(negedge clk);
    {dcd_n, ri_n, dsr_n, cts_n} = p;
    m_pins_n = p;
    settle(); model_update(); check_all();
  endtask

  task automatic wr_ctrl(logic [7:0] d);
    @(negedge clk);
    ctrl_wr = 1'b1; wr_data = d;
    @(negedge clk);
    ctrl_wr = 1'b0;
    m_ctrl = d[4:0];
    settle(); model_update(); check_all();
  endtask

  task automatic rd_stat();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    m_flags = '0;
    settle(); model_update(); check_all();
  endtask

  task automatic set_en(logic e);
    @(negedge clk);
    msi_en = e; m_en = e;
    settle(); check_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 stat", stat_q, 8'h00);
    chk("R9 ctrl", ctrl_q, 8'h00);
    chk("R9 outs", {4'h0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
    chk("R9 irq", {7'h0, irq}, 8'h00);

    // R10 latency: drive before edge k
    @(negedge clk);
    cts_n = 1'b0; m_pins_n[0] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 not yet", {4'h0, stat_q[4], 2'b00, stat_q[0]}, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R10 visible", {4'h0, stat_q[4], 2'b00, stat_q[0]}, 8'h09);
    settle(); model_update(); check_all();   // R8 irq stays 0 while disabled
    set_en(1'b1);                            // R8 irq rises
    rd_stat();                               // R4 clears

    // R3 ring: leading edge sets nothing, trailing edge sets bit 2
    set_pins(4'b1010);
    chk("R3 no lead flag", {7'h0, stat_q[2]}, 8'h00);
    set_pins(4'b1110);
    chk("R3 trail flag", {7'h0, stat_q[2]}, 8'h01);

    // R4 read coincident with a change: dsr change lands on the read edge
    set_pins(4'b1111);                       // flags now pending
    @(negedge clk);
    dsr_n = 1'b0; m_pins_n[1] = 1'b0;        // before edge k
    @(posedge clk); @(negedge clk);          // after k
    @(posedge clk); @(negedge clk);          // after k+1
    stat_rd = 1'b1;
    @(posedge clk); @(negedge clk);          // edge k+2 with read
    stat_rd = 1'b0;
    m_flags = '0; model_update();
    settle(); check_all();
    chk("R4 kept dsr", {7'h0, stat_q[1]}, 8'h01);
    rd_stat();

    // R5/R6 write with upper bits set
    wr_ctrl(8'hE3);
    chk("R5 upper zero", ctrl_q, 8'h03);
    chk("R6 dtr rts low", {6'h0, rts_n, dtr_n}, 8'h00);
    rd_stat();

    // R7 loopback
    wr_ctrl(8'h1F);
    set_pins(4'h0);                          // ignored in loop
    chk("R7 pins ignored", {4'h0, stat_q[7:4]}, 8'h0F);
    wr_ctrl(8'h10);                          // ri trailing in loop
    rd_stat();
    wr_ctrl(8'h00);
    rd_stat();

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: set_pins(4'($urandom));
        1: wr_ctrl(8'($urandom));
        2: rd_stat();
        default: set_en(1'($urandom));
      endcase
    end
    finish_run();
  end
endmodule